// File: doc/BRIEF.md
# Coded Parallel FIR Filter Bank

This block filters four independent signed sample channels through one common FIR impulse response while adding enough redundancy to check the results by linearity. Before filtering, the four channel samples are encoded into six filter inputs. Inputs one to four are the channels themselves. Input five is the plain sum of the four channels. Input six weights the channels by 1, 2, 3 and 4, and the weights of 2, 3 and 4 are built from shifts and adds. Six identical direct-form tapped-delay-line filters then process the six coded streams. Because the filters are linear and share their coefficients, a fault-free bank always satisfies z5 = z1+z2+z3+z4 and z6 = z1+2·z2+3·z3+4·z4.

A sample is accepted on every clock in which the sample enable is high. All six delay lines advance together, and the six results appear as one aligned, registered set with a valid strobe. A fault-injection mask and a shared error value let a test environment corrupt selected outputs, so that downstream checking logic can be exercised. Syndrome computation and correction are not part of this block.

Top module: `coded_fir_bank`

## Requirements
- R1: While `rst` is high at a rising edge, all delay lines, output registers and `out_vld` are cleared. Immediately after reset, `z1`..`z6` read 0 and `out_vld` reads 0, whatever `smp_en` and the channel inputs did during reset.
- R2: Output zc (c = 1..4) equals Σ h(k)·xc(n−k) for k = 0..3, where n counts accepted samples only and h = {2, 5, −3, 7} is the default tap set (h(0) applies to the newest sample). Samples before reset count as zero.
- R3: Output z5 is the same FIR applied to the coded input x1+x2+x3+x4, so it equals z1+z2+z3+z4 when no fault is injected.
- R4: Output z6 is the same FIR applied to x1+2·x2+3·x3+4·x4, so it equals z1+2·z2+3·z3+4·z4 when no fault is injected.
- R5: No intermediate value overflows. With all channels at −128 or at +127, every output equals its exact full-precision value, sign-extended to the 22-bit output width.
- R6: `out_vld` is high for exactly one cycle, two rising edges after each edge at which `smp_en` was sampled high. Back-to-back samples give back-to-back strobes, and every accepted sample yields exactly one strobe.
- R7: When `smp_en` is low, no sample is consumed, and `z1`..`z6` hold their values in every cycle in which `out_vld` is low.
- R8: Bit i of `fault_mask` (bit 0 for z1 through bit 5 for z6) XORs `fault_val` into output z(i+1). The mask and value are sampled at the edge that loads the result, which is the edge one cycle after the sample's enable edge. Injection does not alter filter state, so later results are clean.
- R9: With `fault_mask` all zero, `fault_val` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Accept one sample on each channel this cycle |
| x1 | input | 8 | Channel 1 sample, signed |
| x2 | input | 8 | Channel 2 sample, signed |
| x3 | input | 8 | Channel 3 sample, signed |
| x4 | input | 8 | Channel 4 sample, signed |
| fault_mask | input | 6 | Per-output fault-injection select, bit 0 = z1 |
| fault_val | input | 22 | Error pattern XORed into selected outputs |
| out_vld | output | 1 | Strobe marking a new aligned result set |
| z1 | output | 22 | Filter 1 result (channel 1), signed |
| z2 | output | 22 | Filter 2 result (channel 2), signed |
| z3 | output | 22 | Filter 3 result (channel 3), signed |
| z4 | output | 22 | Filter 4 result (channel 4), signed |
| z5 | output | 22 | Filter 5 result (sum-coded check), signed |
| z6 | output | 22 | Filter 6 result (weight-coded check), signed |

## Verification
A sample presented with `smp_en` at one edge is registered by the encoder at that edge. Its six filter results are loaded into the output registers at the next edge, so `out_vld` and `z1`..`z6` for that sample are due exactly two cycles after the enable. The fault mask and value must be present in the cycle between those two edges. The driver records the due cycle with each expected result set and sets the fault inputs one cycle after the sample. The monitor samples on the falling edge, pops one entry per strobe, checks that the strobe arrives in the recorded cycle, and checks that the outputs stay unchanged in every cycle without a strobe.

// File: rtl/cfb_pkg.sv
package cfb_pkg;
  localparam int NUM_CH  = 4;
  localparam int NUM_FLT = 6;

  // extra input bits each coded filter needs so its encoder sum cannot overflow
  function automatic int grow_bits(input int idx);
    if (idx < NUM_CH) return 0;
    else if (idx == NUM_CH) return 2;
    else return 4;
  endfunction

  // full-precision accumulator width of one filter
  function automatic int acc_bits(input int in_w, input int c_w, input int taps);
    return in_w + c_w + $clog2(taps);
  endfunction
endpackage

// File: rtl/cfb_encoder.sv
module cfb_encoder
  import cfb_pkg::*;
#(
  parameter int DW = 8,
  localparam int EW = DW + 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [DW-1:0] x   [NUM_CH],
  output logic signed [EW-1:0] enc [NUM_FLT]
);
  logic signed [EW-1:0] xe [NUM_CH];
  logic signed [EW-1:0] sum_all;
  logic signed [EW-1:0] sum_wt;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) xe[c] = EW'(x[c]);
    sum_all = xe[0] + xe[1] + xe[2] + xe[3];
    // weights 2 and 4 are shifts; weight 3 is a shift plus the operand itself
    sum_wt  = xe[0] + (xe[1] <<< 1) + ((xe[2] <<< 1) + xe[2]) + (xe[3] <<< 2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int f = 0; f < NUM_FLT; f++) enc[f] <= '0;
    end else if (en) begin
      for (int c = 0; c < NUM_CH; c++) enc[c] <= xe[c];
      enc[NUM_CH]   <= sum_all;
      enc[NUM_CH+1] <= sum_wt;
    end
  end

  // R2: identity rows pass the channel sample through unchanged
  assert_enc_ident_R2: assert property (@(posedge clk) disable iff (rst)
    $past(en) && !$past(rst) |-> enc[1][DW-1:0] == $past(x[1]));

  // R7: coded inputs hold while no sample is accepted
  assert_enc_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(en) && !$past(rst) |-> $stable(enc[NUM_CH+1]));
endmodule

// File: rtl/cfb_fir.sv
module cfb_fir #(
  parameter int IW   = 8,
  parameter int CW   = 8,
  parameter int NTAP = 4,
  parameter logic [NTAP*CW-1:0] COEF = '0,
  parameter int AW   = IW + CW + $clog2(NTAP)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic signed [IW-1:0] din,
  output logic signed [AW-1:0] acc
);
  logic signed [IW-1:0] dl [NTAP-1];
  logic signed [IW-1:0] tv [NTAP];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NTAP-1; k++) dl[k] <= '0;
    end else if (adv) begin
      dl[0] <= din;
      for (int k = 1; k < NTAP-1; k++) dl[k] <= dl[k-1];
    end
  end

  always_comb begin
    logic signed [AW-1:0] a_ext;
    logic signed [AW-1:0] c_ext;
    tv[0] = din;
    for (int k = 1; k < NTAP; k++) tv[k] = dl[k-1];
    acc = '0;
    for (int k = 0; k < NTAP; k++) begin
      a_ext = AW'(tv[k]);
      c_ext = AW'($signed(COEF[k*CW +: CW]));
      acc   = acc + a_ext * c_ext;
    end
  end

  // R7: the delay line does not move without an advance
  assert_line_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(adv) && !$past(rst) |-> $stable(dl[0]));

  // R2: an advance loads the newest input into the first delay stage
  assert_line_load_R2: assert property (@(posedge clk) disable iff (rst)
    $past(adv) && !$past(rst) |-> dl[0] == $past(din));
endmodule

// File: rtl/coded_fir_bank.sv
module coded_fir_bank
  import cfb_pkg::*;
#(
  parameter int DW   = 8,
  parameter int CW   = 8,
  parameter int NTAP = 4,
  parameter logic [NTAP*CW-1:0] COEF = 32'h07FD0502,
  localparam int ZW  = acc_bits(DW + 4, CW, NTAP)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_en,
  input  logic signed [DW-1:0] x1,
  input  logic signed [DW-1:0] x2,
  input  logic signed [DW-1:0] x3,
  input  logic signed [DW-1:0] x4,
  input  logic [NUM_FLT-1:0]   fault_mask,
  input  logic [ZW-1:0]        fault_val,
  output logic                 out_vld,
  output logic signed [ZW-1:0] z1,
  output logic signed [ZW-1:0] z2,
  output logic signed [ZW-1:0] z3,
  output logic signed [ZW-1:0] z4,
  output logic signed [ZW-1:0] z5,
  output logic signed [ZW-1:0] z6
);
  localparam int EW = DW + 4;

  logic signed [DW-1:0] xin  [NUM_CH];
  logic signed [EW-1:0] enc  [NUM_FLT];
  logic signed [ZW-1:0] accx [NUM_FLT];
  logic signed [ZW-1:0] zr   [NUM_FLT];
  logic                 enc_vld;

  assign xin[0] = x1;
  assign xin[1] = x2;
  assign xin[2] = x3;
  assign xin[3] = x4;

  cfb_encoder #(.DW(DW)) u_enc (
    .clk (clk),
    .rst (rst),
    .en  (smp_en),
    .x   (xin),
    .enc (enc)
  );

  for (genvar g = 0; g < NUM_FLT; g++) begin : g_flt
    localparam int IW = DW + grow_bits(g);
    localparam int AW = acc_bits(IW, CW, NTAP);
    logic signed [AW-1:0] acc_w;
    logic signed [IW-1:0] din_w;

    assign din_w = enc[g][IW-1:0];

    cfb_fir #(
      .IW   (IW),
      .CW   (CW),
      .NTAP (NTAP),
      .COEF (COEF),
      .AW   (AW)
    ) u_fir (
      .clk (clk),
      .rst (rst),
      .adv (enc_vld),
      .din (din_w),
      .acc (acc_w)
    );

    assign accx[g] = ZW'(acc_w);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enc_vld <= 1'b0;
      out_vld <= 1'b0;
      for (int f = 0; f < NUM_FLT; f++) zr[f] <= '0;
    end else begin
      enc_vld <= smp_en;
      out_vld <= enc_vld;
      if (enc_vld) begin
        for (int f = 0; f < NUM_FLT; f++)
          zr[f] <= accx[f] ^ (fault_mask[f] ? fault_val : '0);
      end
    end
  end

  assign z1 = zr[0];
  assign z2 = zr[1];
  assign z3 = zr[2];
  assign z4 = zr[3];
  assign z5 = zr[4];
  assign z6 = zr[5];

  // R6: every accepted sample strobes two edges later
  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    $past(smp_en, 2) && !$past(rst) && !$past(rst, 2) |-> out_vld);

  // R6: no strobe without a sample two edges earlier
  assert_no_spurious_R6: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(smp_en, 2));

  // R7: outputs hold between strobes
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !out_vld && !$past(rst) |->
      $stable(z1) && $stable(z2) && $stable(z3) && $stable(z4) && $stable(z5) && $stable(z6));

  // R3: sum-coded filter agrees with the four channel filters when clean
  assert_sum_check_R3: assert property (@(posedge clk) disable iff (rst)
    out_vld && $past(fault_mask) == '0 |-> z5 == ZW'(z1 + z2 + z3 + z4));

  // R4: weight-coded filter agrees with the weighted channel outputs when clean
  assert_wt_check_R4: assert property (@(posedge clk) disable iff (rst)
    out_vld && $past(fault_mask) == '0 |->
      z6 == ZW'(z1 + (z2 <<< 1) + (z3 + (z3 <<< 1)) + (z4 <<< 2)));
endmodule

// File: tb/sim_coded_fir_bank.sv
module sim_coded_fir_bank;
  localparam int DW = 8;
  localparam int NTAP = 4;
  localparam int ZW = 22;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_en = 1'b0;
  logic signed [DW-1:0] x1 = '0, x2 = '0, x3 = '0, x4 = '0;
  logic [5:0] fault_mask = '0;
  logic [ZW-1:0] fault_val = '0;
  logic out_vld;
  logic signed [ZW-1:0] z1, z2, z3, z4, z5, z6;

  always #2 clk = ~clk;

  coded_fir_bank u0 (
    .clk(clk), .rst(rst), .smp_en(smp_en),
    .x1(x1), .x2(x2), .x3(x3), .x4(x4),
    .fault_mask(fault_mask), .fault_val(fault_val),
    .out_vld(out_vld),
    .z1(z1), .z2(z2), .z3(z3), .z4(z4), .z5(z5), .z6(z6)
  );

  typedef struct packed {
    logic [5:0][ZW-1:0] z;
    logic [5:0]         m;
    logic [3:0]         tag;
    int                 due;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  longint hist [6][NTAP];
  int coef [NTAP] = '{2, 5, -3, 7};
  logic [ZW-1:0] zp [6];
  logic [ZW-1:0] last_z [6];

  assign zp[0] = z1;
  assign zp[1] = z2;
  assign zp[2] = z3;
  assign zp[3] = z4;
  assign zp[4] = z5;
  assign zp[5] = z6;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic string tag_of(input int i, input logic [5:0] m, input logic [3:0] t);
    if (m[i]) return "R8";
    if (t == 4'd9) return "R9";
    if (t == 4'd5) return "R5";
    if (i < 4) return "R2";
    if (i == 4) return "R3";
    return "R4";
  endfunction

  task automatic model_push(input int a, input int b, input int c, input int d,
                            input logic [5:0] m, input logic [ZW-1:0] e, input logic [3:0] t);
    longint cin [6];
    longint s;
    exp_t it;
    cin[0] = a; cin[1] = b; cin[2] = c; cin[3] = d;
    cin[4] = a + b + c + d;
    cin[5] = a + 2*b + 3*c + 4*d;
    for (int f = 0; f < 6; f++) begin
      for (int k = NTAP-1; k > 0; k--) hist[f][k] = hist[f][k-1];
      hist[f][0] = cin[f];
      s = 0;
      for (int k = 0; k < NTAP; k++) s += coef[k] * hist[f][k];
      it.z[f] = s[ZW-1:0] ^ (m[f] ? e : '0);
    end
    it.m = m;
    it.tag = t;
    it.due = cyc + 2;
    q.push_back(it);
  endtask

  task automatic put_x(input int a, input int b, input int c, input int d);
    x1 = a[DW-1:0]; x2 = b[DW-1:0]; x3 = c[DW-1:0]; x4 = d[DW-1:0];
  endtask

  // one sample, then the fault inputs in the cycle its result is loaded
  task automatic send(input int a, input int b, input int c, input int d,
                      input logic [5:0] m, input logic [ZW-1:0] e, input logic [3:0] t);
    @(negedge clk);
    put_x(a, b, c, d);
    smp_en = 1'b1; fault_mask = '0; fault_val = '0;
    model_push(a, b, c, d, m, e, t);
    @(negedge clk);
    smp_en = 1'b0; fault_mask = m; fault_val = e;
  endtask

  // back-to-back sample, no injection
  task automatic burst(input int a, input int b, input int c, input int d);
    @(negedge clk);
    put_x(a, b, c, d);
    smp_en = 1'b1; fault_mask = '0; fault_val = '0;
    model_push(a, b, c, d, '0, '0, 4'd0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_en = 1'b0; fault_mask = '0; fault_val = '0;
      put_x(int'($urandom_range(255)), 3, -7, 100);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_vld) begin
        if (q.size() == 0) begin
          chk(1'b0, "R6 unexpected strobe", 1, 0);
        end else begin
          exp_t it;
          it = q.pop_front();
          chk(cyc == it.due, "R6 strobe cycle", cyc, it.due);
          for (int i = 0; i < 6; i++)
            chk(zp[i] === it.z[i], tag_of(i, it.m, it.tag), zp[i], it.z[i]);
        end
      end else begin
        for (int i = 0; i < 6; i++)
          chk(zp[i] === last_z[i], "R7 hold", zp[i], last_z[i]);
      end
      for (int i = 0; i < 6; i++) last_z[i] = zp[i];
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (!done && cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL R6: watchdog expired, actual cycle %0d expected finish", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < 6; f++)
      for (int k = 0; k < NTAP; k++) hist[f][k] = 0;
    for (int i = 0; i < 6; i++) last_z[i] = '0;

    // R1: reset dominates activity on the inputs
    rst = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      smp_en = 1'b1; put_x(55, -90, 17, 127);
      fault_mask = 6'h3F; fault_val = 22'h15555;
    end
    @(negedge clk);
    smp_en = 1'b0; fault_mask = '0; fault_val = '0;
    rst = 1'b0;
    @(negedge clk);
    chk(out_vld == 1'b0, "R1 out_vld", out_vld, 0);
    for (int i = 0; i < 6; i++) chk(zp[i] == '0, "R1 output", zp[i], 0);
    mon_on = 1'b1;

    // R2: impulse on channel 1 walks out the tap set
    send(1, 0, 0, 0, '0, '0, 4'd0);
    for (int i = 0; i < 4; i++) send(0, 0, 0, 0, '0, '0, 4'd0);
    // R7: gap with enable low and moving inputs
    idle(5);
    // R2 R3 R4: distinct channel patterns
    send(10, -20, 30, -40, '0, '0, 4'd0);
    send(-1, 2, -3, 4, '0, '0, 4'd0);
    send(50, 50, -50, -50, '0, '0, 4'd0);
    idle(3);
    // R5: extremes
    for (int i = 0; i < 4; i++) send(-128, -128, -128, -128, '0, '0, 4'd5);
    for (int i = 0; i < 4; i++) send(127, 127, 127, 127, '0, '0, 4'd5);
    send(127, -128, 127, -128, '0, '0, 4'd5);
    // R8: single-output and all-output injection, then clean follow-ups
    for (int b = 0; b < 6; b++) send(9 * b, -3, b, 11, 6'(1 << b), 22'h00A5C3 + 22'(b), 4'd0);
    send(4, 4, 4, 4, 6'h3F, 22'h3FFFFF, 4'd0);
    send(1, 2, 3, 4, '0, '0, 4'd0);
    // R9: non-zero error value with empty mask
    send(-5, 6, -7, 8, '0, 22'h3FFFFF, 4'd9);
    send(20, 21, 22, 23, '0, 22'h12345, 4'd9);
    // R6: back-to-back samples
    for (int i = 0; i < 10; i++) burst(i * 13 - 60, 7 - i, i * i, -i * 9);
    idle(4);
    // mixed traffic
    for (int i = 0; i < 40; i++) begin
      int a, b, c, d;
      a = int'($urandom_range(255)) - 128;
      b = int'($urandom_range(255)) - 128;
      c = int'($urandom_range(255)) - 128;
      d = int'($urandom_range(255)) - 128;
      if (i % 3 == 0) burst(a, b, c, d);
      else send(a, b, c, d, '0, '0, 4'd0);
    end
    idle(6);
    chk(q.size() == 0, "R6 all results delivered", q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule